// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides whether a transaction address seen on the primary side of a PCI-to-PCI bridge should be claimed and passed to the secondary side. It rebuilds three address windows from the raw base and limit register fields: one I/O window, one non-prefetchable memory window and one prefetchable memory window. Each window has its own granularity and an optional upper-word extension.

Each window is gated by the matching space enable from the command register. A window whose limit is below its base is empty. When the legacy display enable is set, the fixed legacy display memory range and the two legacy display I/O ranges are claimed as well.

The window decode is combinational, and the decoded bases and limits are driven out for observation. The claim decision for a request is registered. It appears one clock after the request is presented, together with a vector that shows which source claimed it.

Top module: `bridge_window_decode`

## Requirements
- R1: The I/O window base is {U, B[7:4], 12'h000} and its limit is {V, L[7:4], 12'hFFF}. Here B and L are the 8-bit base and limit fields. U and V are the 16-bit upper registers when the field's low nibble equals 4'h1 (32-bit I/O), and zero otherwise. Bits 63:32 of both values are zero.
- R2: The non-prefetchable memory window base is {B[15:4], 20'h00000} and its limit is {L[15:4], 20'hFFFFF}. The field's low nibble is ignored and bits 63:32 are zero.
- R3: The prefetchable window base is {U, B[15:4], 20'h00000} and its limit is {V, L[15:4], 20'hFFFFF}. U and V are the 32-bit upper registers when that field's low nibble equals 4'h1 (64-bit), and zero otherwise.
- R4: A window whose limit is below its base claims no address, including its base and limit values.
- R5: The I/O space enable gates the I/O window. The memory space enable gates both memory windows. A disabled window claims nothing.
- R6: With the legacy display enable set, memory requests in 0xA0000–0xBFFFF are claimed. I/O requests in 0x3B0–0x3BB and in 0x3C0–0x3DF are also claimed. Each range is inclusive at both ends and is not affected by the space enables.
- R7: I/O requests (space flag 1) are matched only against the I/O window and the legacy I/O ranges. Memory requests (flag 0) are matched only against the two memory windows and the legacy memory range. All comparisons use the full 64-bit address.
- R8: The claim output and the source vector are registered one cycle after the request. The source vector is bit 0 I/O window, bit 1 memory window, bit 2 prefetchable window, bit 3 legacy display range. The claim output is the OR of the vector, and the valid output echoes the request valid of the previous cycle.
- R9: Reset clears valid, claim and source vector. A cycle without a request valid yields claim 0 and source vector 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_base_fld | input | 8 | I/O base field (bits 7:4 address, 3:0 type) |
| io_limit_fld | input | 8 | I/O limit field |
| io_base_hi | input | 16 | I/O base upper 16 bits |
| io_limit_hi | input | 16 | I/O limit upper 16 bits |
| mem_base_fld | input | 16 | Memory base field |
| mem_limit_fld | input | 16 | Memory limit field |
| pf_base_fld | input | 16 | Prefetchable base field (bits 3:0 type) |
| pf_limit_fld | input | 16 | Prefetchable limit field |
| pf_base_hi | input | 32 | Prefetchable base upper 32 bits |
| pf_limit_hi | input | 32 | Prefetchable limit upper 32 bits |
| io_en | input | 1 | I/O space enable |
| mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy display forwarding enable |
| req_valid | input | 1 | Request present |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 64 | Request address |
| io_win_base | output | 32 | Decoded I/O base |
| io_win_limit | output | 32 | Decoded I/O limit |
| mem_win_base | output | 32 | Decoded memory base |
| mem_win_limit | output | 32 | Decoded memory limit |
| pf_win_base | output | 64 | Decoded prefetchable base |
| pf_win_limit | output | 64 | Decoded prefetchable limit |
| claim_vld | output | 1 | Registered request valid |
| claim_fwd | output | 1 | Registered forward decision |
| claim_src | output | 4 | Registered claiming sources |

## Verification
A memory request can be claimed by the legacy display range and by a memory window in the same cycle. The prefetchable and non-prefetchable windows can also overlap each other. The bench provokes these cases by placing a window over 0xA0000–0xBFFFF with the display enable on, and by letting random fields produce overlapping windows. It then requires every matching bit in the source vector to be set together, with a single claim. The space enables are varied as well, so that a disabled window drops out while the display range still claims.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    localparam int ADDR_W      = 64;
    localparam int IO_W        = 32;
    localparam int MEM_W       = 32;
    localparam int IO_GRAN     = 12;
    localparam int MEM_GRAN    = 20;
    localparam int SRC_N       = 4;
    localparam logic [3:0] WIDE_CODE = 4'h1;

    localparam int SRC_IO   = 0;
    localparam int SRC_MEM  = 1;
    localparam int SRC_PF   = 2;
    localparam int SRC_VGA  = 3;

    localparam logic [ADDR_W-1:0] VGA_MEM_LO  = 64'h0000_0000_000A_0000;
    localparam logic [ADDR_W-1:0] VGA_MEM_HI  = 64'h0000_0000_000B_FFFF;
    localparam logic [ADDR_W-1:0] VGA_IOA_LO  = 64'h3B0;
    localparam logic [ADDR_W-1:0] VGA_IOA_HI  = 64'h3BB;
    localparam logic [ADDR_W-1:0] VGA_IOB_LO  = 64'h3C0;
    localparam logic [ADDR_W-1:0] VGA_IOB_HI  = 64'h3DF;

    typedef enum logic [1:0] {
        WK_IO   = 2'd0,
        WK_MEM  = 2'd1,
        WK_PF   = 2'd2
    } win_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              open;
    } win_t;

    typedef struct packed {
        logic             vld;
        logic             fwd;
        logic [SRC_N-1:0] src;
    } claim_t;
endpackage

// File: rtl/bwd_window_build.sv
module bwd_window_build
    import bwd_pkg::*;
#(
    parameter win_kind_e KIND = WK_MEM
) (
    input  logic [15:0] base_fld,
    input  logic [15:0] limit_fld,
    input  logic [31:0] base_hi,
    input  logic [31:0] limit_hi,
    input  logic        en,
    output win_t        win
);
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] limit_w;

    generate
        if (KIND == WK_IO) begin : g_io
            logic        wide_b, wide_l;
            logic [15:0] up_b, up_l;
            logic        unused_io;
            assign wide_b = (base_fld[3:0] == WIDE_CODE);
            assign wide_l = (limit_fld[3:0] == WIDE_CODE);
            assign up_b   = wide_b ? base_hi[15:0] : 16'h0;
            assign up_l   = wide_l ? limit_hi[15:0] : 16'h0;
            assign base_w  = {{(ADDR_W-IO_W){1'b0}}, up_b, base_fld[7:4], {IO_GRAN{1'b0}}};
            assign limit_w = {{(ADDR_W-IO_W){1'b0}}, up_l, limit_fld[7:4], {IO_GRAN{1'b1}}};
            assign unused_io = ^{base_fld[15:8], limit_fld[15:8], base_hi[31:16], limit_hi[31:16]};
        end else if (KIND == WK_MEM) begin : g_mem
            logic unused_mem;
            assign base_w  = {{(ADDR_W-MEM_W){1'b0}}, base_fld[15:4], {MEM_GRAN{1'b0}}};
            assign limit_w = {{(ADDR_W-MEM_W){1'b0}}, limit_fld[15:4], {MEM_GRAN{1'b1}}};
            assign unused_mem = ^{base_fld[3:0], limit_fld[3:0], base_hi, limit_hi};
        end else begin : g_pf
            logic        wide_b, wide_l;
            logic [31:0] up_b, up_l;
            assign wide_b = (base_fld[3:0] == WIDE_CODE);
            assign wide_l = (limit_fld[3:0] == WIDE_CODE);
            assign up_b   = wide_b ? base_hi : 32'h0;
            assign up_l   = wide_l ? limit_hi : 32'h0;
            assign base_w  = {up_b, base_fld[15:4], {MEM_GRAN{1'b0}}};
            assign limit_w = {up_l, limit_fld[15:4], {MEM_GRAN{1'b1}}};
        end
    endgenerate

    always_comb begin
        win.base  = base_w;
        win.limit = limit_w;
        win.open  = en && (limit_w >= base_w);
    end
endmodule

// File: rtl/bwd_range_hit.sv
module bwd_range_hit
    import bwd_pkg::*;
(
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              open,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = open && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
    import bwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  io_base_fld,
    input  logic [7:0]  io_limit_fld,
    input  logic [15:0] io_base_hi,
    input  logic [15:0] io_limit_hi,
    input  logic [15:0] mem_base_fld,
    input  logic [15:0] mem_limit_fld,
    input  logic [15:0] pf_base_fld,
    input  logic [15:0] pf_limit_fld,
    input  logic [31:0] pf_base_hi,
    input  logic [31:0] pf_limit_hi,
    input  logic        io_en,
    input  logic        mem_en,
    input  logic        vga_en,
    input  logic        req_valid,
    input  logic        req_is_io,
    input  logic [63:0] req_addr,
    output logic [31:0] io_win_base,
    output logic [31:0] io_win_limit,
    output logic [31:0] mem_win_base,
    output logic [31:0] mem_win_limit,
    output logic [63:0] pf_win_base,
    output logic [63:0] pf_win_limit,
    output logic        claim_vld,
    output logic        claim_fwd,
    output logic [3:0]  claim_src
);
    localparam int NWIN = 3;

    win_t            win [NWIN];
    logic [NWIN-1:0] win_hit;
    logic [2:0]      vga_hit;
    claim_t          st_d, st_q;

    bwd_window_build #(.KIND(WK_IO)) u_io_win (
        .base_fld  ({8'h00, io_base_fld}),
        .limit_fld ({8'h00, io_limit_fld}),
        .base_hi   ({16'h0000, io_base_hi}),
        .limit_hi  ({16'h0000, io_limit_hi}),
        .en        (io_en),
        .win       (win[SRC_IO])
    );

    bwd_window_build #(.KIND(WK_MEM)) u_mem_win (
        .base_fld  (mem_base_fld),
        .limit_fld (mem_limit_fld),
        .base_hi   (32'h0),
        .limit_hi  (32'h0),
        .en        (mem_en),
        .win       (win[SRC_MEM])
    );

    bwd_window_build #(.KIND(WK_PF)) u_pf_win (
        .base_fld  (pf_base_fld),
        .limit_fld (pf_limit_fld),
        .base_hi   (pf_base_hi),
        .limit_hi  (pf_limit_hi),
        .en        (mem_en),
        .win       (win[SRC_PF])
    );

    genvar gi;
    generate
        for (gi = 0; gi < NWIN; gi++) begin : g_hit
            bwd_range_hit u_hit (
                .lo   (win[gi].base),
                .hi   (win[gi].limit),
                .open (win[gi].open),
                .addr (req_addr),
                .hit  (win_hit[gi])
            );
        end
    endgenerate

    bwd_range_hit u_vga_mem (
        .lo (VGA_MEM_LO), .hi (VGA_MEM_HI), .open (vga_en),
        .addr (req_addr), .hit (vga_hit[0])
    );
    bwd_range_hit u_vga_ioa (
        .lo (VGA_IOA_LO), .hi (VGA_IOA_HI), .open (vga_en),
        .addr (req_addr), .hit (vga_hit[1])
    );
    bwd_range_hit u_vga_iob (
        .lo (VGA_IOB_LO), .hi (VGA_IOB_HI), .open (vga_en),
        .addr (req_addr), .hit (vga_hit[2])
    );

    logic unused_win;
    assign unused_win = ^{win[SRC_IO].base[63:32], win[SRC_IO].limit[63:32],
                          win[SRC_MEM].base[63:32], win[SRC_MEM].limit[63:32]};

    always_comb begin
        st_d     = '0;
        st_d.vld = req_valid;
        if (req_valid) begin
            if (req_is_io) begin
                st_d.src[SRC_IO]  = win_hit[SRC_IO];
                st_d.src[SRC_VGA] = vga_hit[1] | vga_hit[2];
            end else begin
                st_d.src[SRC_MEM] = win_hit[SRC_MEM];
                st_d.src[SRC_PF]  = win_hit[SRC_PF];
                st_d.src[SRC_VGA] = vga_hit[0];
            end
        end
        st_d.fwd = |st_d.src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_win_base   = win[SRC_IO].base[IO_W-1:0];
    assign io_win_limit  = win[SRC_IO].limit[IO_W-1:0];
    assign mem_win_base  = win[SRC_MEM].base[MEM_W-1:0];
    assign mem_win_limit = win[SRC_MEM].limit[MEM_W-1:0];
    assign pf_win_base   = win[SRC_PF].base;
    assign pf_win_limit  = win[SRC_PF].limit;
    assign claim_vld     = st_q.vld;
    assign claim_fwd     = st_q.fwd;
    assign claim_src     = st_q.src;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_is_io,
    input logic [63:0] req_addr,
    input logic        io_en,
    input logic        mem_en,
    input logic        vga_en,
    input logic [31:0] mem_win_base,
    input logic [31:0] mem_win_limit,
    input logic        claim_vld,
    input logic        claim_fwd,
    input logic [3:0]  claim_src
);
    p_io_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !io_en) |=> !claim_src[0]);

    p_mem_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !mem_en) |=> (!claim_src[1] && !claim_src[2]));

    p_space_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io) |=> !claim_src[0]);

    p_io_space_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io) |=> (!claim_src[1] && !claim_src[2]));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!claim_fwd && claim_src == 4'h0 && !claim_vld));

    p_vga_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && vga_en &&
         req_addr >= 64'hA0000 && req_addr <= 64'hBFFFF) |=> (claim_fwd && claim_src[3]));

    p_empty_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && mem_win_limit < mem_win_base) |=> !claim_src[1]);

    p_valid_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> claim_vld);
endmodule

bind bridge_window_decode bwd_checker u_bwd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_is_io     (req_is_io),
    .req_addr      (req_addr),
    .io_en         (io_en),
    .mem_en        (mem_en),
    .vga_en        (vga_en),
    .mem_win_base  (mem_win_base),
    .mem_win_limit (mem_win_limit),
    .claim_vld     (claim_vld),
    .claim_fwd     (claim_fwd),
    .claim_src     (claim_src)
);

// File: tb/sim_bridge_window_decode.sv
`timescale 1ns/1ps
module sim_bridge_window_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_base_fld = '0, io_limit_fld = '0;
    logic [15:0] io_base_hi = '0, io_limit_hi = '0;
    logic [15:0] mem_base_fld = '0, mem_limit_fld = '0;
    logic [15:0] pf_base_fld = '0, pf_limit_fld = '0;
    logic [31:0] pf_base_hi = '0, pf_limit_hi = '0;
    logic        io_en = 1'b0, mem_en = 1'b0, vga_en = 1'b0;
    logic        req_valid = 1'b0, req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic [31:0] io_win_base, io_win_limit, mem_win_base, mem_win_limit;
    logic [63:0] pf_win_base, pf_win_limit;
    logic        claim_vld, claim_fwd;
    logic [3:0]  claim_src;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bridge_window_decode u0 (.*);

    function automatic logic [63:0] m_io(input logic [7:0] f, input logic [15:0] h, input bit lim);
        return {32'h0, (f[3:0] == 4'h1) ? h : 16'h0, f[7:4], lim ? 12'hFFF : 12'h000};
    endfunction
    function automatic logic [63:0] m_mem(input logic [15:0] f, input bit lim);
        return {32'h0, f[15:4], lim ? 20'hFFFFF : 20'h00000};
    endfunction
    function automatic logic [63:0] m_pf(input logic [15:0] f, input logic [31:0] h, input bit lim);
        return {(f[3:0] == 4'h1) ? h : 32'h0, f[15:4], lim ? 20'hFFFFF : 20'h00000};
    endfunction
    function automatic bit inr(input logic [63:0] a, input logic [63:0] lo, input logic [63:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
    function automatic logic [3:0] m_src();
        logic [3:0] s = 4'h0;
        if (!req_valid) return s;
        if (req_is_io) begin
            s[0] = io_en && inr(req_addr, m_io(io_base_fld, io_base_hi, 0),
                                          m_io(io_limit_fld, io_limit_hi, 1));
            s[3] = vga_en && (inr(req_addr, 64'h3B0, 64'h3BB) || inr(req_addr, 64'h3C0, 64'h3DF));
        end else begin
            s[1] = mem_en && inr(req_addr, m_mem(mem_base_fld, 0), m_mem(mem_limit_fld, 1));
            s[2] = mem_en && inr(req_addr, m_pf(pf_base_fld, pf_base_hi, 0),
                                           m_pf(pf_limit_fld, pf_limit_hi, 1));
            s[3] = vga_en && inr(req_addr, 64'hA0000, 64'hBFFFF);
        end
        return s;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present a request, check windows now, check claim after one edge
    task automatic issue(input string tag, input bit v, input bit io, input logic [63:0] a);
        logic [3:0] exp_src;
        req_valid = v; req_is_io = io; req_addr = a;
        #1;
        chk({tag, " R1 io base"},  {32'h0, io_win_base},  m_io(io_base_fld, io_base_hi, 0));
        chk({tag, " R1 io limit"}, {32'h0, io_win_limit}, m_io(io_limit_fld, io_limit_hi, 1));
        chk({tag, " R2 mem base"}, {32'h0, mem_win_base}, m_mem(mem_base_fld, 0));
        chk({tag, " R2 mem limit"},{32'h0, mem_win_limit},m_mem(mem_limit_fld, 1));
        chk({tag, " R3 pf base"},  pf_win_base,  m_pf(pf_base_fld, pf_base_hi, 0));
        chk({tag, " R3 pf limit"}, pf_win_limit, m_pf(pf_limit_fld, pf_limit_hi, 1));
        exp_src = m_src();
        @(negedge clk);
        chk({tag, " R8 src"}, {60'h0, claim_src}, {60'h0, exp_src});
        chk({tag, " R8 fwd"}, {63'h0, claim_fwd}, {63'h0, |exp_src});
        chk({tag, " R8 vld"}, {63'h0, claim_vld}, {63'h0, v});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        #23;
        chk("R9 reset vld", {63'h0, claim_vld}, 64'h0);
        chk("R9 reset fwd", {63'h0, claim_fwd}, 64'h0);
        chk("R9 reset src", {60'h0, claim_src}, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1: 16-bit I/O window 0x2000..0x3FFF
        io_base_fld = 8'h20; io_limit_fld = 8'h30; io_base_hi = 16'hAAAA; io_limit_hi = 16'hBBBB;
        io_en = 1;
        issue("R1 io16 base", 1, 1, 64'h2000);
        issue("R1 io16 limit", 1, 1, 64'h3FFF);
        issue("R1 io16 above", 1, 1, 64'h4000);
        // R1: 32-bit I/O
        io_base_fld = 8'h21; io_limit_fld = 8'h31; io_base_hi = 16'h0001; io_limit_hi = 16'h0001;
        issue("R1 io32 in", 1, 1, 64'h1_3FFF);
        issue("R1 io32 low miss", 1, 1, 64'h3000);
        // R7: memory request at I/O window address
        issue("R7 mem at io addr", 1, 0, 64'h1_2000);
        // R5: I/O disabled
        io_en = 0;
        issue("R5 io off", 1, 1, 64'h1_2000);
        // R2: memory window 0x0010_0000..0x002F_FFFF
        mem_en = 1; mem_base_fld = 16'h001F; mem_limit_fld = 16'h0020;
        issue("R2 mem base", 1, 0, 64'h0010_0000);
        issue("R2 mem limit", 1, 0, 64'h002F_FFFF);
        issue("R2 mem beyond", 1, 0, 64'h0030_0000);
        issue("R7 mem 4G alias", 1, 0, 64'h1_0010_0000);
        issue("R7 io at mem addr", 1, 1, 64'h0010_0000);
        // R3: 64-bit prefetchable
        pf_base_fld = 16'h8001; pf_limit_fld = 16'h8011; pf_base_hi = 32'h2; pf_limit_hi = 32'h2;
        issue("R3 pf64 in", 1, 0, 64'h2_8000_0000);
        issue("R3 pf64 top", 1, 0, 64'h2_801F_FFFF);
        issue("R3 pf64 low miss", 1, 0, 64'h8000_0000);
        pf_base_fld = 16'h8000; pf_limit_fld = 16'h8010;
        issue("R3 pf32 in", 1, 0, 64'h8000_0000);
        // R4: limit below base
        mem_base_fld = 16'h0050; mem_limit_fld = 16'h0040;
        issue("R4 empty mem base", 1, 0, 64'h0050_0000);
        issue("R4 empty mem limit", 1, 0, 64'h004F_FFFF);
        // R5: memory disabled kills both memory windows
        mem_en = 0;
        issue("R5 mem off pf", 1, 0, 64'h8000_0000);
        // R6: legacy display ranges with overlapping memory window
        vga_en = 1; mem_en = 1; mem_base_fld = 16'h0000; mem_limit_fld = 16'h0000;
        issue("R6 vga mem lo overlap", 1, 0, 64'hA0000);
        mem_en = 0;
        issue("R6 vga mem hi", 1, 0, 64'hBFFFF);
        issue("R6 vga mem above", 1, 0, 64'hC0000);
        issue("R6 vga ioa lo", 1, 1, 64'h3B0);
        issue("R6 vga ioa hi", 1, 1, 64'h3BB);
        issue("R6 vga gap", 1, 1, 64'h3BC);
        issue("R6 vga iob lo", 1, 1, 64'h3C0);
        issue("R6 vga iob hi", 1, 1, 64'h3DF);
        issue("R6 vga iob above", 1, 1, 64'h3E0);
        vga_en = 0;
        issue("R6 vga off", 1, 0, 64'hA0000);
        // R9: no request
        vga_en = 1;
        issue("R9 idle", 0, 0, 64'hA0000);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            io_base_fld = 8'($urandom); io_base_fld[3:0] = 4'($urandom % 2);
            io_limit_fld = 8'($urandom); io_limit_fld[3:0] = 4'($urandom % 2);
            io_base_hi = 16'($urandom % 3); io_limit_hi = 16'($urandom % 3);
            mem_base_fld = 16'($urandom); mem_limit_fld = 16'($urandom);
            pf_base_fld = 16'($urandom); pf_base_fld[3:0] = 4'($urandom % 2);
            pf_limit_fld = 16'($urandom); pf_limit_fld[3:0] = 4'($urandom % 2);
            pf_base_hi = 32'($urandom % 3); pf_limit_hi = 32'($urandom % 3);
            io_en = 1'($urandom); mem_en = 1'($urandom); vga_en = 1'($urandom);
            case ($urandom % 8)
                0: a = m_io(io_base_fld, io_base_hi, 0);
                1: a = m_io(io_limit_fld, io_limit_hi, 1) + 64'd1;
                2: a = m_mem(mem_base_fld, 0) - 64'd1;
                3: a = m_mem(mem_limit_fld, 1);
                4: a = m_pf(pf_base_fld, pf_base_hi, 0);
                5: a = m_pf(pf_limit_fld, pf_limit_hi, 1);
                6: a = 64'h3A0 + 64'($urandom % 64) + (($urandom % 2) ? 64'hA0000 - 64'h3A0 : 64'h0);
                default: a = {32'($urandom % 4), 32'($urandom)};
            endcase
            issue("rand", 1'($urandom % 8 != 0), 1'($urandom), a);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule